// File: doc/BRIEF.md
# Gated Parallel Modulation Data Assembler

This block takes 16-bit words from an external parallel port and turns them into modulation parameters for a synthesizer core. It produces a 14-bit amplitude, a 16-bit phase offset and a 32-bit frequency tuning word. The port has its own strobe clock, and the block samples it inside a single system clock domain. A configuration bit picks which strobe edge is active, so no logic runs on two clock edges.

A transmit-enable input gates capture, and a second configuration bit can invert its polarity. A 2-bit destination code sets how a captured word maps onto the parameters:

| Code | Mapping |
|------|---------|
| 00 | The top 14 bits of the word form the amplitude. |
| 01 | The whole word forms the phase. |
| 10 | The word is shifted by a 4-bit gain and added to a base tuning word. |
| 11 | The upper byte goes to the amplitude and the lower byte goes to the phase. Register inputs fill the missing low bits of both. |

While the gate is false, the block does one of two things, chosen by a configuration bit. It either rebuilds the outputs from an all-zero word on every cycle, or it holds the outputs from the last captured word.

Top module: `mod_data_assembler`

## Requirements
- R1: After reset, `amp_o`, `phase_o`, `freq_o` and `valid_o` are all zero.
- R2: With `dest_i`=00, `amp_o` equals `word[15:2]`, and `word[1:0]` has no effect. `phase_o` and `freq_o` are zero.
- R3: With `dest_i`=01, `phase_o` equals the whole word. `amp_o` and `freq_o` are zero.
- R4: With `dest_i`=10, `freq_o` equals `(ftw_base_i + (word << fm_gain_i)) mod 2^32`, where the word is zero-extended and the gain ranges from 0 to 15. `amp_o` and `phase_o` are zero.
- R5: With `dest_i`=11, `amp_o` equals `{word[15:8], amp_fill_i[5:0]}`, `phase_o` equals `{word[7:0], phase_fill_i[7:0]}`, and `freq_o` is zero.
- R6: The gate is true when `txen_i` XOR `txen_inv_i` is 1. A port edge seen while the gate is false captures nothing.
- R7: A word is captured only on the selected strobe edge: rising when `pclk_inv_i`=0, falling when `pclk_inv_i`=1. The opposite edge captures nothing. The outputs update on the second system clock edge after the strobe change is first registered.
- R8: While the gate is false and `hold_last_i`=0, the outputs equal the mapping of an all-zero word under the current configuration.
- R9: While the gate is false and `hold_last_i`=1, the outputs keep the values from the last capture.
- R10: `valid_o` is high for exactly one cycle per captured word, in the same cycle the new outputs appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pclk_i | input | 1 | Parallel port strobe |
| txen_i | input | 1 | Transmit enable gate |
| data_i | input | 16 | Parallel port word |
| dest_i | input | 2 | Destination code |
| pclk_inv_i | input | 1 | 1 selects the falling strobe edge |
| txen_inv_i | input | 1 | 1 makes the gate active low |
| hold_last_i | input | 1 | 1 holds the outputs while gated, 0 clears them |
| amp_fill_i | input | 6 | Amplitude low bits used in split mode |
| phase_fill_i | input | 8 | Phase low bits used in split mode |
| ftw_base_i | input | 32 | Base frequency tuning word |
| fm_gain_i | input | 4 | Left shift applied to the word in frequency mode |
| amp_o | output | 14 | Amplitude parameter |
| phase_o | output | 16 | Phase parameter |
| freq_o | output | 32 | Frequency tuning word |
| valid_o | output | 1 | One-cycle strobe for each new capture |

## Verification
On every cycle, the assertions check four things:
- the strobe lasts a single cycle;
- a capture only follows a true gate;
- the outputs stay stable while gated in hold mode;
- the outputs are zero while gated in clear mode in phase mode, and the split-mode fill bits follow the fill register on each capture.

The arithmetic of each mapping depends on data values, and only the bench's sweeps can show it. These sweeps cover words under every destination code, every gain with wrap-around, both edge polarities and both gate polarities. The same applies to the rule that the inactive strobe edge captures nothing.

// File: rtl/mda_pkg.sv
package mda_pkg;
  typedef enum logic [1:0] {
    DEST_AMP   = 2'b00,
    DEST_PHASE = 2'b01,
    DEST_FREQ  = 2'b10,
    DEST_SPLIT = 2'b11
  } dest_e;
endpackage

// File: rtl/mda_port_sampler.sv
module mda_port_sampler #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pclk_i,
  input  logic          txen_i,
  input  logic [DW-1:0] data_i,
  input  logic          pclk_inv_i,
  input  logic          txen_inv_i,
  input  logic          hold_last_i,
  output logic          cap_o,
  output logic          clr_o,
  output logic          gate_o,
  output logic [DW-1:0] data_o
);
  logic          pclk_s1, pclk_s2, txen_s1;
  logic [DW-1:0] data_s1;
  logic          edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_s1 <= 1'b0;
      pclk_s2 <= 1'b0;
      txen_s1 <= 1'b0;
      data_s1 <= '0;
    end else begin
      pclk_s1 <= pclk_i;
      pclk_s2 <= pclk_s1;
      txen_s1 <= txen_i;
      data_s1 <= data_i;
    end
  end

  // selected edge of the port strobe, seen in the system domain
  assign edge_hit = pclk_inv_i ? (pclk_s2 & ~pclk_s1) : (pclk_s1 & ~pclk_s2);
  assign gate_o   = txen_s1 ^ txen_inv_i;
  assign cap_o    = edge_hit & gate_o;
  assign clr_o    = ~gate_o & ~hold_last_i;
  assign data_o   = data_s1;
endmodule

// File: rtl/mda_freq_scale.sv
module mda_freq_scale #(
  parameter int DW = 16,
  parameter int FW = 32,
  parameter int GW = 4
) (
  input  logic [DW-1:0] word_i,
  input  logic [GW-1:0] gain_i,
  input  logic [FW-1:0] base_i,
  output logic [FW-1:0] freq_o
);
  logic [FW-1:0] ext, scaled;

  assign ext    = FW'(word_i);
  assign scaled = ext << gain_i;
  assign freq_o = base_i + scaled; // wraps modulo 2^FW
endmodule

// File: rtl/mda_param_map.sv
module mda_param_map
  import mda_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 14,
  parameter int PW = 16,
  parameter int FW = 32,
  parameter int GW = 4,
  localparam int HALF  = DW / 2,
  localparam int AFILL = AW - HALF,
  localparam int PFILL = PW - HALF
) (
  input  logic [DW-1:0]    word_i,
  input  dest_e            dest_i,
  input  logic [AFILL-1:0] amp_fill_i,
  input  logic [PFILL-1:0] phase_fill_i,
  input  logic [FW-1:0]    base_i,
  input  logic [GW-1:0]    gain_i,
  output logic [AW-1:0]    amp_o,
  output logic [PW-1:0]    phase_o,
  output logic [FW-1:0]    freq_o
);
  logic [FW-1:0] freq_sum;

  mda_freq_scale #(.DW(DW), .FW(FW), .GW(GW)) u_freq_scale (
    .word_i (word_i),
    .gain_i (gain_i),
    .base_i (base_i),
    .freq_o (freq_sum)
  );

  always_comb begin
    amp_o   = '0;
    phase_o = '0;
    freq_o  = '0;
    unique case (dest_i)
      DEST_AMP:   amp_o   = word_i[DW-1 -: AW];
      DEST_PHASE: phase_o = word_i[DW-1 -: PW];
      DEST_FREQ:  freq_o  = freq_sum;
      DEST_SPLIT: begin
        amp_o   = {word_i[DW-1 -: HALF], amp_fill_i};
        phase_o = {word_i[HALF-1:0], phase_fill_i};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mod_data_assembler.sv
module mod_data_assembler
  import mda_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 14,
  parameter int PW = 16,
  parameter int FW = 32,
  parameter int GW = 4,
  localparam int HALF  = DW / 2,
  localparam int AFILL = AW - HALF,
  localparam int PFILL = PW - HALF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pclk_i,
  input  logic             txen_i,
  input  logic [DW-1:0]    data_i,
  input  logic [1:0]       dest_i,
  input  logic             pclk_inv_i,
  input  logic             txen_inv_i,
  input  logic             hold_last_i,
  input  logic [AFILL-1:0] amp_fill_i,
  input  logic [PFILL-1:0] phase_fill_i,
  input  logic [FW-1:0]    ftw_base_i,
  input  logic [GW-1:0]    fm_gain_i,
  output logic [AW-1:0]    amp_o,
  output logic [PW-1:0]    phase_o,
  output logic [FW-1:0]    freq_o,
  output logic             valid_o
);
  logic          cap, clr, gate;
  logic [DW-1:0] port_word, map_word;
  logic [AW-1:0] amp_d, amp_q;
  logic [PW-1:0] phase_d, phase_q;
  logic [FW-1:0] freq_d, freq_q;
  logic          valid_q;

  mda_port_sampler #(.DW(DW)) u_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pclk_i      (pclk_i),
    .txen_i      (txen_i),
    .data_i      (data_i),
    .pclk_inv_i  (pclk_inv_i),
    .txen_inv_i  (txen_inv_i),
    .hold_last_i (hold_last_i),
    .cap_o       (cap),
    .clr_o       (clr),
    .gate_o      (gate),
    .data_o      (port_word)
  );

  // a clear rebuilds the outputs from an all-zero word
  assign map_word = cap ? port_word : '0;

  mda_param_map #(.DW(DW), .AW(AW), .PW(PW), .FW(FW), .GW(GW)) u_map (
    .word_i       (map_word),
    .dest_i       (dest_e'(dest_i)),
    .amp_fill_i   (amp_fill_i),
    .phase_fill_i (phase_fill_i),
    .base_i       (ftw_base_i),
    .gain_i       (fm_gain_i),
    .amp_o        (amp_d),
    .phase_o      (phase_d),
    .freq_o       (freq_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_q   <= '0;
      phase_q <= '0;
      freq_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap;
      if (cap || clr) begin
        amp_q   <= amp_d;
        phase_q <= phase_d;
        freq_q  <= freq_d;
      end
    end
  end

  assign amp_o   = amp_q;
  assign phase_o = phase_q;
  assign freq_o  = freq_q;
  assign valid_o = valid_q;

  assert_valid_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_capture_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(gate));

  assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate && hold_last_i) |=> ($stable(amp_o) && $stable(phase_o) && $stable(freq_o)));

  assert_clear_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate && !hold_last_i && dest_i == 2'b01) |=> (amp_o == '0 && phase_o == '0 && freq_o == '0));

  assert_split_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dest_i) == 2'b11) |-> (amp_o[AFILL-1:0] == $past(amp_fill_i)
                                            && phase_o[PFILL-1:0] == $past(phase_fill_i)));
endmodule

// File: tb/mod_data_assembler_bench.sv
module mod_data_assembler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pclk = 1'b0, txen = 1'b0, pclk_inv = 1'b0, txen_inv = 1'b0, hold = 1'b0;
  logic [15:0] data = '0;
  logic [1:0]  dest = '0;
  logic [5:0]  afill = '0;
  logic [7:0]  pfill = '0;
  logic [31:0] base = '0;
  logic [3:0]  gain = '0;
  logic [13:0] amp;
  logic [15:0] phase;
  logic [31:0] freq;
  logic        valid;

  int checks = 0;
  int failures = 0;
  logic [13:0] e_amp = '0;
  logic [15:0] e_phase = '0;
  logic [31:0] e_freq = '0;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  mod_data_assembler u_mod_data_assembler (
    .clk_i(clk), .rst_ni(rst_n), .pclk_i(pclk), .txen_i(txen), .data_i(data),
    .dest_i(dest), .pclk_inv_i(pclk_inv), .txen_inv_i(txen_inv), .hold_last_i(hold),
    .amp_fill_i(afill), .phase_fill_i(pfill), .ftw_base_i(base), .fm_gain_i(gain),
    .amp_o(amp), .phase_o(phase), .freq_o(freq), .valid_o(valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] w);
    e_amp = '0; e_phase = '0; e_freq = '0;
    case (dest)
      2'd0: e_amp = 14'(w >> 2);
      2'd1: e_phase = w;
      2'd2: e_freq = base + ({16'h0, w} << gain);
      default: begin
        e_amp   = 14'({8'h0, w[15:8]} * 64 + afill);
        e_phase = 16'({8'h0, w[7:0]} * 256 + pfill);
      end
    endcase
  endtask

  function automatic string dtag();
    case (dest)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_outs(input string tag);
    check(tag, 32'(amp), 32'(e_amp));
    check(tag, 32'(phase), 32'(e_phase));
    check(tag, freq, e_freq);
  endtask

  // one port transfer: settle, active edge, check, inactive edge with new data
  task automatic xfer(input logic [15:0] w, input logic en, input string tag);
    int vcnt;
    logic gate_t;
    gate_t = en ^ txen_inv;
    @(negedge clk);
    data = w; txen = en; pclk = pclk_inv;
    repeat (3) @(negedge clk);
    pclk = ~pclk_inv;
    vcnt = 0;
    repeat (4) begin
      @(negedge clk);
      if (valid) vcnt++;
    end
    if (gate_t) model(w);
    else if (!hold) model(16'h0);
    check(tag, 32'(vcnt), gate_t ? 32'd1 : 32'd0);
    check_outs(tag);
    // inactive edge must not capture (R7)
    data = ~w; pclk = pclk_inv;
    vcnt = 0;
    repeat (4) begin
      @(negedge clk);
      if (valid) vcnt++;
    end
    check("R7", 32'(vcnt), 32'd0);
    check_outs("R7");
  endtask

  function automatic logic [15:0] nxt();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[31:16];
  endfunction

  initial begin
    afill = 6'h2b; pfill = 8'hc5; base = 32'hfff0_1234;
    repeat (3) @(negedge clk);
    check("R1", 32'(amp), 0); check("R1", 32'(phase), 0);
    check("R1", freq, 0); check("R1", 32'(valid), 0);
    rst_n = 1'b1;
    // R2 R3 R5 sweeps, plus D[1:0] ignored in amplitude mode
    for (int d = 0; d < 4; d++) begin
      if (d == 2) continue;
      dest = 2'(d);
      xfer(16'hffff, 1'b1, dtag());
      xfer(16'h0000, 1'b1, dtag());
      xfer(16'h8001, 1'b1, dtag());
      for (int k = 0; k < 16; k++) xfer(nxt(), 1'b1, dtag());
    end
    dest = 2'd0;
    xfer(16'ha5a7, 1'b1, "R2");
    xfer(16'ha5a4, 1'b1, "R2");
    // R4 every gain with wrap
    dest = 2'd2;
    for (int g = 0; g < 16; g++) begin
      gain = 4'(g);
      xfer(16'hffff, 1'b1, "R4");
      xfer(nxt(), 1'b1, "R4");
    end
    // R7 falling-edge selection
    pclk = 1'b1; pclk_inv = 1'b1;
    dest = 2'd3;
    for (int k = 0; k < 6; k++) xfer(nxt(), 1'b1, "R7");
    pclk = 1'b0; pclk_inv = 1'b0;
    repeat (2) @(negedge clk);
    // R9 hold while gated
    hold = 1'b1; dest = 2'd1;
    xfer(16'h1357, 1'b1, "R3");
    xfer(16'h2468, 1'b0, "R9");
    xfer(16'h9999, 1'b0, "R9");
    // R8 clear while gated, across modes
    hold = 1'b0;
    xfer(16'h4444, 1'b0, "R8");
    dest = 2'd2; gain = 4'd3;
    xfer(16'h5555, 1'b0, "R8");
    dest = 2'd3;
    xfer(16'h6666, 1'b0, "R8");
    // R6 inverted gate polarity
    txen_inv = 1'b1; dest = 2'd0;
    xfer(16'hbeef, 1'b0, "R6");
    hold = 1'b1;
    xfer(16'h1111, 1'b1, "R6");
    dest = 2'd1;
    xfer(16'hcafe, 1'b0, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule